// File: doc/BRIEF.md
# Conditional Branch and Skip Evaluator

This block decides whether a conditional change of program flow is taken and produces the program counter of the next instruction together with the number of cycles that decision costs. A decoder presents one request per cycle: the kind of test, a bit selector, the status byte, the operands the test looks at, a signed 7-bit displacement, the current program counter and whether the instruction after the current one occupies two words. One cycle later the block presents the next PC, a taken flag and the cycle count.

Flag branches test one selected bit of the status byte for set or clear. The signed comparisons derive their condition from N and V directly rather than from a stored sign bit. Skips compare two bytes for equality or test one bit of a register or I/O byte, and when they hold they step over the following instruction by one or two words. Fetch and decode lie outside the block.

Top module: `branch_eval`

## Requirements
- R1: While reset is asserted and after it is released with no request, res_valid, taken, next_pc and cycles are all zero.
- R2: A result appears on res_valid exactly one clock after req_valid is sampled high, one result per request, and res_valid is low in every cycle that follows a cycle without a request.
- R3: Kind 0 (flag set) is taken exactly when sreg[sel] is 1; sel 0 (carry) gives the unsigned lower test and sel 7 (interrupt enable) uses the same path.
- R4: Kind 1 (flag clear) is taken exactly when sreg[sel] is 0; sel 0 gives the unsigned same-or-higher test.
- R5: A taken branch (kinds 0 to 3) gives next_pc = pc + sign-extended offset + 1 and cycles = 2; the offset is 7-bit two's complement covering -64 to +63.
- R6: Kind 2 (signed greater-or-equal) is taken when sreg[2] XOR sreg[3] is 0 and kind 3 (signed less-than) when it is 1; sreg[4] has no effect on either.
- R7: Kind 4 (equality skip) is taken exactly when opa equals opb.
- R8: Kind 5 (bit-clear skip) is taken when bit_src[sel] is 0, kind 6 (bit-set skip) when bit_src[sel] is 1.
- R9: A taken skip (kinds 4 to 6) gives next_pc = pc + 2 and cycles = 2 when skip_two_word is 0, and next_pc = pc + 3 and cycles = 3 when it is 1.
- R10: A request that is not taken gives next_pc = pc + 1 and cycles = 1, whatever the offset and skip_two_word.
- R11: Kind 7 is reserved and is never taken.
- R12: All PC arithmetic wraps modulo 2^PCW (PCW = 12 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| kind | input | 3 | Test kind, encoding in R3 to R11 |
| sel | input | 3 | Bit index for flag and bit tests |
| sreg | input | 8 | Status byte (C=0, N=2, V=3, S=4, I=7) |
| opa | input | 8 | First equality operand |
| opb | input | 8 | Second equality operand |
| bit_src | input | 8 | Register or I/O byte for bit skips |
| offset | input | 7 | Signed branch displacement |
| pc | input | PCW | Current program counter |
| skip_two_word | input | 1 | Following instruction is two words long |
| res_valid | output | 1 | Result present |
| next_pc | output | PCW | Program counter of the next instruction |
| taken | output | 1 | Flow change taken |
| cycles | output | 2 | Cycles spent on the decision (1 to 3) |

## Verification
The assertions take for granted that every input, including kind and pc, holds the value of the request for the whole cycle in which req_valid is high, since they look back one cycle at those inputs to relate them to the result. The stimulus changes inputs only on the falling clock edge and drops req_valid when idle, so each sampled request is stable and self-consistent. Operand fields a kind does not use are driven to values that would flip the outcome if they leaked in, such as a set S bit for the signed tests and a two-word flag on branches.

// File: rtl/branch_eval.sv
module branch_eval #(
  parameter int PCW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [2:0]     kind,
  input  logic [2:0]     sel,
  input  logic [7:0]     sreg,
  input  logic [7:0]     opa,
  input  logic [7:0]     opb,
  input  logic [7:0]     bit_src,
  input  logic [6:0]     offset,
  input  logic [PCW-1:0] pc,
  input  logic           skip_two_word,
  output logic           res_valid,
  output logic [PCW-1:0] next_pc,
  output logic           taken,
  output logic [1:0]     cycles
);

  localparam int NEG_BIT = 2;
  localparam int OVF_BIT = 3;
  localparam int EXT     = PCW - 7;

  localparam logic [2:0] K_FSET = 3'd0;
  localparam logic [2:0] K_FCLR = 3'd1;
  localparam logic [2:0] K_SGE  = 3'd2;
  localparam logic [2:0] K_SLT  = 3'd3;
  localparam logic [2:0] K_SEQ  = 3'd4;
  localparam logic [2:0] K_BCLR = 3'd5;
  localparam logic [2:0] K_BSET = 3'd6;

  logic           is_branch, is_skip, cond, signed_lt;
  logic [PCW-1:0] disp, pc_seq, pc_br, pc_skip, pc_nxt;
  logic [1:0]     cyc_nxt;

  assign signed_lt = sreg[NEG_BIT] ^ sreg[OVF_BIT];
  assign is_branch = (kind <= K_SLT);
  assign is_skip   = (kind >= K_SEQ) && (kind <= K_BSET);

  always_comb begin
    case (kind)
      K_FSET:  cond = sreg[sel];
      K_FCLR:  cond = !sreg[sel];
      K_SGE:   cond = !signed_lt;
      K_SLT:   cond = signed_lt;
      K_SEQ:   cond = (opa == opb);
      K_BCLR:  cond = !bit_src[sel];
      K_BSET:  cond = bit_src[sel];
      default: cond = 1'b0;
    endcase
  end

  assign disp    = {{EXT{offset[6]}}, offset};
  assign pc_seq  = pc + PCW'(1);
  assign pc_br   = pc_seq + disp;
  assign pc_skip = pc + (skip_two_word ? PCW'(3) : PCW'(2));

  always_comb begin
    pc_nxt  = pc_seq;
    cyc_nxt = 2'd1;
    if (cond && is_branch) begin
      pc_nxt  = pc_br;
      cyc_nxt = 2'd2;
    end else if (cond && is_skip) begin
      pc_nxt  = pc_skip;
      cyc_nxt = skip_two_word ? 2'd3 : 2'd2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      next_pc   <= '0;
      taken     <= 1'b0;
      cycles    <= 2'd0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        next_pc <= pc_nxt;
        taken   <= cond && (is_branch || is_skip);
        cycles  <= cyc_nxt;
      end
    end
  end

  a_r2_one_per_request: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(req_valid));

  a_r10_not_taken_steps_one: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !taken) |-> (cycles == 2'd1 && next_pc == $past(pc) + PCW'(1)));

  a_r9_skip_advance_matches_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && taken && $past(kind) >= K_SEQ) |-> (next_pc == $past(pc) + PCW'(cycles)));

  a_r5_branch_costs_two: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && taken && $past(kind) <= K_SLT) |-> (cycles == 2'd2));

  a_r11_reserved_never_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(kind) == 3'd7) |-> !taken);

  a_r6_signed_pair_complementary: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(kind) == K_SGE) |-> (taken == ($past(sreg[NEG_BIT]) == $past(sreg[OVF_BIT]))));

  a_r1_reset_idle: assert property (@(posedge clk)
    !$past(rst_n) |-> (!res_valid && !taken && cycles == 2'd0));

endmodule

// File: tb/branch_eval_test.sv
module branch_eval_test;
  localparam int PCW = 12;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0;
  logic [2:0]     kind = '0, sel = '0;
  logic [7:0]     sreg = '0, opa = '0, opb = '0, bit_src = '0;
  logic [6:0]     offset = '0;
  logic [PCW-1:0] pc = '0;
  logic           skip_two_word = 1'b0;
  logic           res_valid, taken;
  logic [PCW-1:0] next_pc;
  logic [1:0]     cycles;

  int n_checks = 0, n_fail = 0;
  bit armed = 1'b0, done = 1'b0;

  logic [PCW-1:0] q_pc[$];
  logic           q_tk[$];
  logic [1:0]     q_cy[$];
  string          q_req[$];

  always #5 clk = ~clk;

  branch_eval #(.PCW(PCW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .kind(kind), .sel(sel),
    .sreg(sreg), .opa(opa), .opb(opb), .bit_src(bit_src), .offset(offset),
    .pc(pc), .skip_two_word(skip_two_word), .res_valid(res_valid),
    .next_pc(next_pc), .taken(taken), .cycles(cycles));

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(string req, logic [2:0] k, logic [2:0] s, logic [7:0] st,
                      logic [7:0] a, logic [7:0] b, logic [7:0] bs,
                      logic [6:0] off, logic [PCW-1:0] p, logic tw);
    logic c;
    logic [PCW-1:0] ep;
    logic [1:0] ec;
    int d;
    @(negedge clk);
    kind = k; sel = s; sreg = st; opa = a; opb = b; bit_src = bs;
    offset = off; pc = p; skip_two_word = tw; req_valid = 1'b1;
    case (k)
      3'd0: c = st[s];
      3'd1: c = !st[s];
      3'd2: c = (st[2] == st[3]);
      3'd3: c = (st[2] != st[3]);
      3'd4: c = (a == b);
      3'd5: c = !bs[s];
      3'd6: c = bs[s];
      default: c = 1'b0;
    endcase
    d = (off >= 7'd64) ? int'(off) - 128 : int'(off);
    if (!c) begin ep = p + 1; ec = 2'd1; end
    else if (k <= 3'd3) begin ep = PCW'(int'(p) + d + 1); ec = 2'd2; end
    else begin ep = p + (tw ? 3 : 2); ec = tw ? 2'd3 : 2'd2; end
    q_pc.push_back(ep); q_tk.push_back(c); q_cy.push_back(ec); q_req.push_back(req);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (armed) begin
      if (q_req.size() == 0) begin
        check("R2", "res_valid idle", int'(res_valid), 0);
      end else begin
        string r;
        r = q_req.pop_front();
        check("R2", "res_valid", int'(res_valid), 1);
        check(r, "next_pc", int'(next_pc), int'(q_pc.pop_front()));
        check(r, "taken", int'(taken), int'(q_tk.pop_front()));
        check(r, "cycles", int'(cycles), int'(q_cy.pop_front()));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "res_valid in reset", int'(res_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "res_valid", int'(res_valid), 0);
    check("R1", "taken", int'(taken), 0);
    check("R1", "next_pc", int'(next_pc), 0);
    check("R1", "cycles", int'(cycles), 0);
    armed = 1'b1;
    // R3 R5: carry set (lower) taken, positive offset, two-word flag ignored
    send("R3", 3'd0, 3'd0, 8'h01, 8'h00, 8'h00, 8'h00, 7'd5, 12'd100, 1'b1);
    send("R3", 3'd0, 3'd0, 8'hFE, 8'h00, 8'h00, 8'h00, 7'd5, 12'd100, 1'b0);
    send("R5", 3'd0, 3'd7, 8'h80, 8'h00, 8'h00, 8'h00, 7'h40, 12'd200, 1'b0);
    // R4: flag clear, max positive offset
    send("R4", 3'd1, 3'd1, 8'hFD, 8'h00, 8'h00, 8'h00, 7'd63, 12'd10, 1'b0);
    send("R4", 3'd1, 3'd1, 8'h02, 8'h00, 8'h00, 8'h00, 7'd63, 12'd10, 1'b1);
    send("R4", 3'd1, 3'd0, 8'h00, 8'h00, 8'h00, 8'h00, 7'h7F, 12'd50, 1'b0);
    idle(2);
    // R6: signed tests from N xor V, S bit set inconsistently
    send("R6", 3'd2, 3'd0, 8'h0C, 8'h00, 8'h00, 8'h00, 7'd3, 12'd300, 1'b0);
    send("R6", 3'd2, 3'd0, 8'h04, 8'h00, 8'h00, 8'h00, 7'd3, 12'd300, 1'b0);
    send("R6", 3'd3, 3'd0, 8'h08, 8'h00, 8'h00, 8'h00, 7'h7C, 12'd300, 1'b0);
    send("R6", 3'd3, 3'd0, 8'h10, 8'h00, 8'h00, 8'h00, 7'd9, 12'd300, 1'b0);
    // R7 R9: equality skip over one and two words
    send("R7", 3'd4, 3'd0, 8'hFF, 8'h5A, 8'h5A, 8'h00, 7'd20, 12'd400, 1'b0);
    send("R9", 3'd4, 3'd0, 8'h00, 8'hA5, 8'hA5, 8'h00, 7'd20, 12'd400, 1'b1);
    send("R10", 3'd4, 3'd0, 8'hFF, 8'hA5, 8'hA4, 8'h00, 7'd20, 12'd400, 1'b1);
    // R8: bit skips
    send("R8", 3'd5, 3'd3, 8'hFF, 8'h00, 8'h01, 8'hF7, 7'd0, 12'd500, 1'b0);
    send("R8", 3'd5, 3'd3, 8'h00, 8'h00, 8'h01, 8'h08, 7'd0, 12'd500, 1'b1);
    send("R8", 3'd6, 3'd5, 8'h00, 8'h00, 8'h01, 8'h20, 7'd0, 12'd500, 1'b1);
    send("R8", 3'd6, 3'd5, 8'hFF, 8'h00, 8'h01, 8'hDF, 7'd0, 12'd500, 1'b0);
    idle(1);
    // R11: reserved kind with every condition true
    send("R11", 3'd7, 3'd0, 8'hFF, 8'h11, 8'h11, 8'hFF, 7'd9, 12'd600, 1'b1);
    // R12: wrap-around
    send("R12", 3'd0, 3'd6, 8'h40, 8'h00, 8'h00, 8'h00, 7'd1, 12'hFFF, 1'b0);
    send("R12", 3'd1, 3'd6, 8'h00, 8'h00, 8'h00, 8'h00, 7'h7B, 12'd2, 1'b0);
    send("R12", 3'd6, 3'd0, 8'h00, 8'h00, 8'h00, 8'h01, 7'd0, 12'hFFE, 1'b1);
    send("R12", 3'd0, 3'd0, 8'h00, 8'h00, 8'h00, 8'h00, 7'd0, 12'hFFF, 1'b0);
    idle(4);
    check("R2", "queue drained", q_req.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule